// File: doc/BRIEF.md
# Shaped-Density Pseudorandom Bit Source

This block produces one pseudorandom bit per enabled clock cycle from a linear feedback shift register whose length is chosen at run time among seven maximal-length sequences. Test equipment and built-in self-test logic use it to drive serial links and logic under test with data whose statistics look like real traffic.

A shaping stage after the register can lower the share of ones in the stream. It does this by ANDing the current bit with one or two earlier bits of the same sequence, spaced one or three bits apart. A final inversion gives the complementary densities. The output is registered, so it lags the register's leading bit by one enabled cycle. While the enable input is low, every register holds its value.

Top module: `prbs_mark_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `dout` becomes 0, the sequence register loads all ones, the bit history clears to zeros, and the current `len_sel` is captured as the active length.
- R2: With `mark_sel` at 0 and `invert` low, `dout` repeats with period 2^n-1, where `len_sel` codes 0 to 6 select n = 7, 9, 11, 15, 20, 23, 31.
- R3: The raw bit is register bit n-1. On each enabled edge, the register shifts one place toward its top bit and takes bit n-1 XOR bit t-1 into bit 0. The tap t is 6, 5, 9, 14, 3, 18, 28 for codes 0 to 6. On the same edge, `dout` takes the shaped value of the current raw bit.
- R4: `mark_sel` = 0 passes the raw bit unchanged (density 2^(n-1) ones per period).
- R5: `mark_sel` = 1 ANDs the raw bit with the raw bit s enabled cycles earlier, where `long_shift` = 0 gives s = 1 and `long_shift` = 1 gives s = 3 (density 2^(n-2) ones per period).
- R6: `mark_sel` = 2 ANDs the raw bit with the raw bits s and 2s enabled cycles earlier (density 2^(n-3) ones per period).
- R7: `mark_sel` = 3 forces the shaped value to 0.
- R8: `invert` high complements the shaped value, so a ratio of k ones per period becomes 2^n-1-k, and `mark_sel` = 3 gives all ones.
- R9: While `en` is low, `dout`, the register, the bit history and the active length hold, and `len_sel` changes are not acted on.
- R10: At the first enabled edge where `len_sel` differs from the active length, the register loads all ones instead of advancing, and the new code becomes active. `dout` and the history advance as on any enabled edge, using the raw bit taken at position n-1 of the new code. The register is never all zeros.
- R11: `len_sel` code 7 behaves exactly like code 0 (n = 7, tap 6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable |
| len_sel | input | 3 | Sequence length code |
| mark_sel | input | 2 | Ones-density code |
| long_shift | input | 1 | Spacing of ANDed copies: 0 gives 1 bit, 1 gives 3 bits |
| invert | input | 1 | Complement the shaped output |
| dout | output | 1 | Serial data bit |

## Verification
A wrong feedback tap or register index does not stay hidden. The period of `dout` no longer equals 2^n-1, and a bit-exact comparison against an independent model diverges within a few dozen cycles of reset. A wrong history depth or spacing leaves the period intact but moves the count of ones over one full period away from 2^(n-2) or 2^(n-3), so one period of the shortest sequence is enough to expose it. A hold or reload fault shows up as `dout` changing while `en` is low, or as a mismatch against the model in the cycles right after a length change.

// File: rtl/prbs_mark_pkg.sv
package prbs_mark_pkg;

    // Longest supported register and width of an index into it
    localparam int MAX_ORDER = 31;
    localparam int IDX_W     = $clog2(MAX_ORDER + 1);

    typedef enum logic [2:0] {
        LEN_7   = 3'd0,
        LEN_9   = 3'd1,
        LEN_11  = 3'd2,
        LEN_15  = 3'd3,
        LEN_20  = 3'd4,
        LEN_23  = 3'd5,
        LEN_31  = 3'd6,
        LEN_ALT = 3'd7
    } len_sel_e;

    typedef enum logic [1:0] {
        MARK_HALF    = 2'd0,
        MARK_QUARTER = 2'd1,
        MARK_EIGHTH  = 2'd2,
        MARK_NONE    = 2'd3
    } mark_e;

    // Feedback polynomial x^order + x^tap + 1
    typedef struct packed {
        logic [IDX_W-1:0] order;
        logic [IDX_W-1:0] tap;
    } poly_t;

    function automatic poly_t poly_of(input len_sel_e sel);
        poly_t p;
        case (sel)
            LEN_9:   begin p.order = IDX_W'(9);  p.tap = IDX_W'(5);  end
            LEN_11:  begin p.order = IDX_W'(11); p.tap = IDX_W'(9);  end
            LEN_15:  begin p.order = IDX_W'(15); p.tap = IDX_W'(14); end
            LEN_20:  begin p.order = IDX_W'(20); p.tap = IDX_W'(3);  end
            LEN_23:  begin p.order = IDX_W'(23); p.tap = IDX_W'(18); end
            LEN_31:  begin p.order = IDX_W'(31); p.tap = IDX_W'(28); end
            default: begin p.order = IDX_W'(7);  p.tap = IDX_W'(6);  end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
    import prbs_mark_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  len_sel_e             len_code,
    output logic                 raw,
    output logic [MAX_ORDER-1:0] state
);

    logic [MAX_ORDER-1:0] state_q;
    len_sel_e             code_q;
    poly_t                poly;
    logic [IDX_W-1:0]     top_idx;
    logic [IDX_W-1:0]     tap_idx;
    logic                 feedback;
    logic                 reload;

    always_comb begin
        poly     = poly_of(len_code);
        top_idx  = poly.order - IDX_W'(1);
        tap_idx  = poly.tap - IDX_W'(1);
        raw      = state_q[top_idx];
        feedback = state_q[top_idx] ^ state_q[tap_idx];
        reload   = (len_code != code_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '1;
            code_q  <= len_code;
        end else if (en) begin
            if (reload) begin
                state_q <= '1;
                code_q  <= len_code;
            end else begin
                state_q <= {state_q[MAX_ORDER-2:0], feedback};
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/prbs_hist.sv
module prbs_hist #(
    parameter int DEPTH = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           raw,
    output logic [DEPTH:1] past
);

    // past[k] holds the raw bit from k enabled cycles ago
    always_ff @(posedge clk) begin
        if (rst) begin
            past <= '0;
        end else if (en) begin
            past <= {past[DEPTH-1:1], raw};
        end
    end

endmodule

// File: rtl/prbs_shaper.sv
module prbs_shaper
    import prbs_mark_pkg::*;
#(
    parameter int SHORT_SHIFT = 1,
    parameter int LONG_SHIFT  = 3,
    parameter int DEPTH       = 2 * LONG_SHIFT
) (
    input  logic           raw,
    input  logic [DEPTH:1] past,
    input  mark_e          mark,
    input  logic           long_shift,
    input  logic           invert,
    output logic           shaped
);

    localparam int COPIES = 2;

    logic [COPIES:1] near_copy;
    logic [COPIES:1] far_copy;
    logic [COPIES:1] sel_copy;
    logic            anded;

    for (genvar k = 1; k <= COPIES; k++) begin : g_copy
        assign near_copy[k] = past[k * SHORT_SHIFT];
        assign far_copy[k]  = past[k * LONG_SHIFT];
    end

    always_comb begin
        sel_copy = long_shift ? far_copy : near_copy;
        case (mark)
            MARK_QUARTER: anded = raw & sel_copy[1];
            MARK_EIGHTH:  anded = raw & sel_copy[1] & sel_copy[2];
            MARK_NONE:    anded = 1'b0;
            default:      anded = raw;
        endcase
        shaped = anded ^ invert;
    end

endmodule

// File: rtl/prbs_mark_gen.sv
module prbs_mark_gen
    import prbs_mark_pkg::*;
#(
    parameter int SHORT_SHIFT = 1,
    parameter int LONG_SHIFT  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [2:0] len_sel,
    input  logic [1:0] mark_sel,
    input  logic       long_shift,
    input  logic       invert,
    output logic       dout
);

    localparam int HIST_DEPTH = 2 * LONG_SHIFT;

    logic                  raw_bit;
    logic [MAX_ORDER-1:0]  lfsr_state;
    logic [HIST_DEPTH:1]   hist;
    logic                  shaped_bit;

    prbs_lfsr u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .len_code (len_sel_e'(len_sel)),
        .raw      (raw_bit),
        .state    (lfsr_state)
    );

    prbs_hist #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .raw  (raw_bit),
        .past (hist)
    );

    prbs_shaper #(
        .SHORT_SHIFT (SHORT_SHIFT),
        .LONG_SHIFT  (LONG_SHIFT),
        .DEPTH       (HIST_DEPTH)
    ) u_shaper (
        .raw        (raw_bit),
        .past       (hist),
        .mark       (mark_e'(mark_sel)),
        .long_shift (long_shift),
        .invert     (invert),
        .shaped     (shaped_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= 1'b0;
        end else if (en) begin
            dout <= shaped_bit;
        end
    end

endmodule

// File: rtl/prbs_mark_gen_chk.sv
module prbs_mark_gen_chk
    import prbs_mark_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic [1:0]           mark_sel,
    input logic                 invert,
    input logic                 dout,
    input logic [MAX_ORDER-1:0] state
);

    // R1: output is low on the cycle after a reset edge
    assert_reset_low_R1: assert property (@(posedge clk)
        $past(rst) |-> !dout);

    // R7: density code 3 without inversion yields zero
    assert_zero_ratio_R7: assert property (@(posedge clk) disable iff (rst)
        (en && mark_sel == 2'd3 && !invert) |=> !dout);

    // R8: density code 3 with inversion yields one
    assert_full_ratio_R8: assert property (@(posedge clk) disable iff (rst)
        (en && mark_sel == 2'd3 && invert) |=> dout);

    // R9: nothing moves while enable is low
    assert_hold_out_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout));

    assert_hold_state_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state));

    // R10: register never reaches the all-zero lock-up state
    assert_no_lockup_R10: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

bind prbs_mark_gen prbs_mark_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .mark_sel (mark_sel),
    .invert   (invert),
    .dout     (dout),
    .state    (lfsr_state)
);

// File: tb/prbs_mark_gen_tb.sv
module prbs_mark_gen_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [2:0] len_sel;
    logic [1:0] mark_sel;
    logic       long_shift;
    logic       invert;
    logic       dout;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    prbs_mark_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .len_sel    (len_sel),
        .mark_sel   (mark_sel),
        .long_shift (long_shift),
        .invert     (invert),
        .dout       (dout)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [30:0] m_st;
    logic [6:1]  m_h;
    logic        m_dout;
    logic [2:0]  m_code;

    function automatic int order_for(input logic [2:0] c);
        case (c)
            3'd1: return 9;
            3'd2: return 11;
            3'd3: return 15;
            3'd4: return 20;
            3'd5: return 23;
            3'd6: return 31;
            default: return 7;
        endcase
    endfunction

    function automatic int tap_for(input logic [2:0] c);
        case (c)
            3'd1: return 5;
            3'd2: return 9;
            3'd3: return 14;
            3'd4: return 3;
            3'd5: return 18;
            3'd6: return 28;
            default: return 6;
        endcase
    endfunction

    function automatic int ones_expected(input int n, input logic [1:0] m, input logic inv);
        int per;
        int base;
        per = (1 << n) - 1;
        case (m)
            2'd0: base = 1 << (n - 1);
            2'd1: base = 1 << (n - 2);
            2'd2: base = 1 << (n - 3);
            default: base = 0;
        endcase
        return inv ? per - base : base;
    endfunction

    task automatic model_reset();
        m_st   = '1;
        m_h    = '0;
        m_dout = 1'b0;
        m_code = len_sel;
    endtask

    task automatic model_step();
        int   n;
        int   t;
        int   s;
        logic r;
        logic q;
        if (!en) return;
        n = order_for(len_sel);
        t = tap_for(len_sel);
        s = long_shift ? 3 : 1;
        r = m_st[n-1];
        case (mark_sel)
            2'd1: q = r & m_h[s];
            2'd2: q = r & m_h[s] & m_h[2*s];
            2'd3: q = 1'b0;
            default: q = r;
        endcase
        m_dout = q ^ invert;
        m_h    = {m_h[5:1], r};
        if (len_sel != m_code) begin
            m_st   = '1;
            m_code = len_sel;
        end else begin
            m_st = {m_st[29:0], m_st[n-1] ^ m_st[t-1]};
        end
    endtask

    // one clock: model follows the edge, sampling happens at the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst) model_reset();
        else     model_step();
        @(negedge clk);
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] code);
        len_sel = code;
        rst     = 1'b1;
        en      = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    // run n ticks comparing with the model, report mismatches as one check
    task automatic run_compare(input string req, input int n_ticks);
        int mism = 0;
        for (int i = 0; i < n_ticks; i++) begin
            tick();
            if (dout !== m_dout) mism++;
        end
        chk_int(req, mism, 0);
    endtask

    task automatic measure_period(output int p);
        logic [31:0] win = '0;
        logic [31:0] ref_win;
        int cnt = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            win = {win[30:0], dout};
        end
        ref_win = win;
        do begin
            tick();
            win = {win[30:0], dout};
            cnt++;
        end while (win != ref_win && cnt < 40000);
        p = cnt;
    endtask

    task automatic measure_ones(input int n, output int ones);
        ones = 0;
        for (int i = 0; i < 10; i++) tick();
        for (int i = 0; i < (1 << n) - 1; i++) begin
            tick();
            if (dout === 1'b1) ones++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int p;
        int ones;
        int held;
        int moved;
        void'($urandom(32'd20240601));
        rst = 1'b1; en = 1'b1; len_sel = 3'd0; mark_sel = 2'd0;
        long_shift = 1'b0; invert = 1'b0;
        model_reset();
        @(negedge clk);

        // R1: reset state
        do_reset(3'd0);
        chk_int("R1 dout after reset", int'(dout), 0);

        // R3 / R4: exact sequence for the short length
        run_compare("R3 R4 n=7 bit-exact", 300);

        // R2: period for each length that fits the run
        for (int c = 0; c < 4; c++) begin
            mark_sel = 2'd0; invert = 1'b0;
            do_reset(3'(c));
            measure_period(p);
            chk_int($sformatf("R2 period code %0d", c), p, (1 << order_for(3'(c))) - 1);
        end

        // R3: bit-exact against the model for the long lengths
        for (int c = 4; c < 7; c++) begin
            do_reset(3'(c));
            run_compare($sformatf("R3 bit-exact code %0d", c), 3000);
        end

        // R4..R8: ones per full period of n=7 for every density, spacing, inversion
        for (int ls = 0; ls < 2; ls++) begin
            for (int m = 0; m < 4; m++) begin
                for (int iv = 0; iv < 2; iv++) begin
                    mark_sel = 2'(m); long_shift = 1'(ls); invert = 1'(iv);
                    do_reset(3'd0);
                    measure_ones(7, ones);
                    chk_int($sformatf("R4 R5 R6 R7 R8 density m=%0d ls=%0d inv=%0d", m, ls, iv),
                            ones, ones_expected(7, 2'(m), 1'(iv)));
                end
            end
        end

        // R5 / R6: density holds on a longer sequence too (n=11)
        mark_sel = 2'd2; long_shift = 1'b1; invert = 1'b0;
        do_reset(3'd2);
        measure_ones(11, ones);
        chk_int("R6 density n=11 eighth", ones, ones_expected(11, 2'd2, 1'b0));
        mark_sel = 2'd1; long_shift = 1'b0; invert = 1'b1;
        do_reset(3'd2);
        measure_ones(11, ones);
        chk_int("R5 R8 density n=11 quarter inverted", ones, ones_expected(11, 2'd1, 1'b1));

        // R9: enable low holds everything, even across a length change
        mark_sel = 2'd0; long_shift = 1'b0; invert = 1'b0;
        do_reset(3'd1);
        run_compare("R9 pre-hold", 57);
        held  = int'(dout);
        moved = 0;
        en = 1'b0;
        len_sel = 3'd3;
        mark_sel = 2'd3; invert = 1'b1;
        for (int i = 0; i < 25; i++) begin
            tick();
            if (int'(dout) != held) moved++;
        end
        chk_int("R9 dout changes while disabled", moved, 0);
        len_sel = 3'd1; mark_sel = 2'd0; invert = 1'b0;
        en = 1'b1;
        run_compare("R9 resume continues sequence", 400);

        // R10: length change reloads and yields the new period
        mark_sel = 2'd1; long_shift = 1'b1;
        do_reset(3'd0);
        run_compare("R10 before change", 100);
        len_sel = 3'd1;
        run_compare("R10 after change bit-exact", 1100);
        mark_sel = 2'd0;
        measure_period(p);
        chk_int("R10 period after change", p, 511);
        len_sel = 3'd6;
        run_compare("R10 change to n=31 bit-exact", 500);

        // R11: code 7 acts as code 0
        mark_sel = 2'd0; invert = 1'b0;
        do_reset(3'd7);
        run_compare("R11 code 7 bit-exact", 200);
        measure_period(p);
        chk_int("R11 code 7 period", p, 127);

        // Random mix of all controls against the model
        do_reset(3'($urandom % 7));
        for (int seg = 0; seg < 8; seg++) begin
            int mism = 0;
            for (int i = 0; i < 500; i++) begin
                if ($urandom % 20 == 0) mark_sel = 2'($urandom % 4);
                if ($urandom % 20 == 0) invert = 1'($urandom % 2);
                if ($urandom % 20 == 0) long_shift = 1'($urandom % 2);
                if ($urandom % 200 == 0) len_sel = 3'($urandom % 8);
                en = ($urandom % 10) != 0;
                tick();
                if (dout !== m_dout) mism++;
            end
            chk_int($sformatf("R3 R5 R6 R8 R9 R10 random segment %0d", seg), mism, 0);
        end

        finish_run();
    end

endmodule